// File: doc/BRIEF.md
# Transmit FIFO Write Pattern Checker

This block sits between a packet source and the write port of a transmit FIFO. It inspects every accepted word (data, channel address, start and end of packet, a valid-byte modulo field and an error flag) and forwards a repaired word stream to the FIFO one cycle later. The checker counts words since the start of each packet segment to locate credit boundaries. A credit is 16 bytes of packet data, which is 2 words on a 64-bit path and 4 words on a 32-bit path.

Two write patterns are illegal, and each has its own repair. The first is a channel switch in the middle of a credit while the previous word did not end its packet. The checker closes the interrupted packet by inserting an abort marker that carries the old channel, and it stalls the writer for one cycle to make room for it. The second is a non-zero modulo on a word that does not end a packet. The checker forwards that word with the modulo forced to zero and inserts no abort. Either case sets a sticky error, which software clears with a pulse, and fires a one-cycle strobe.

Top module: `fifo_wr_pattern_chk`

## Requirements
- R1: While reset is low and right after it is released, `ff_valid`, `pat_err` and `pat_err_pulse` are 0 and `wr_ready` is 1.
- R2: A legal accepted word (`wr_valid` and `wr_ready` both high) appears on the `ff_*` outputs on the next cycle with its data, channel, SOP, EOP, modulo and error flag unchanged, and with `ff_abort` at 0.
- R3: A credit boundary is reached every 16 bytes, which is 2 words at DATA_W=64 and 4 words at DATA_W=32. The word count restarts at 0 after an EOP word, and restarts at 1 on the word that switches channel. A channel switch at a boundary is legal and is forwarded unchanged.
- R4: A channel switch that is off a credit boundary, following a word without EOP, is a pattern error.
- R5: For an R4 error, the output on the next cycle is an abort marker: data 0, the old channel, SOP 0, EOP 1, abort 1, modulo 0 and error flag 0. The offending word follows on the cycle after that.
- R6: After an R4 error, `wr_ready` is low for exactly one cycle.
- R7: A channel switch right after an EOP word is legal whatever the word count.
- R8: A non-zero modulo on a word without EOP is a pattern error. The word is forwarded with modulo 0 and no abort marker.
- R9: A non-zero modulo on an EOP word is legal and is forwarded unchanged.
- R10: `pat_err` stays set until a cycle with `err_clr` high and no new error. A new error in the same cycle as `err_clr` leaves it set.
- R11: `pat_err_pulse` is high for one cycle per erroneous write. It is aligned with the first output word produced for that write.
- R12: A write that has both the R4 and the R8 condition gives one pulse and gets both repairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write word present |
| wr_ready | output | 1 | Checker can accept a word |
| wr_data | input | DATA_W | Write data |
| wr_chan | input | CHAN_W | Channel address of the word |
| wr_sop | input | 1 | Start of packet |
| wr_eop | input | 1 | End of packet |
| wr_mod | input | MOD_W | Valid-byte modulo, meaningful with EOP |
| wr_err | input | 1 | Error flag carried with the word |
| ff_valid | output | 1 | Word written to FIFO |
| ff_data | output | DATA_W | Forwarded data |
| ff_chan | output | CHAN_W | Forwarded channel |
| ff_sop | output | 1 | Forwarded start of packet |
| ff_eop | output | 1 | Forwarded end of packet |
| ff_abort | output | 1 | Word is an abort termination marker |
| ff_mod | output | MOD_W | Forwarded (repaired) modulo |
| ff_err | output | 1 | Forwarded error flag |
| err_clr | input | 1 | Clears the sticky error |
| pat_err | output | 1 | Sticky pattern error |
| pat_err_pulse | output | 1 | One-cycle strobe per new error |

## Verification
The bench first switches channel exactly at a credit boundary and right after an EOP. A checker with the wrong boundary arithmetic, or one that never restarts the count, would flag these legal writes and emit a spurious abort marker. The bench then switches channel one word into a credit. A broken design there might skip the marker, tag the marker with the new channel, drop the stalled word, or hold `wr_ready` low too long. The remaining cases are a combined violation, which must give one pulse and still zero the modulo on the delayed word, and a clear pulse that coincides with a new error, which must leave the sticky bit set.

// File: rtl/fwpc_pkg.sv
package fwpc_pkg;

   // Violation flags for the word currently presented at the write side.
   typedef struct packed {
      logic addr;   // channel switch inside a credit
      logic modv;   // non-zero modulo without end of packet
   } viol_t;

   function automatic int words_per_credit(input int data_w, input int credit_b);
      return credit_b / (data_w / 8);
   endfunction

endpackage

// File: rtl/fwpc_credit_track.sv
module fwpc_credit_track
   import fwpc_pkg::*;
#(
   parameter int DATA_W       = 64,
   parameter int CHAN_W       = 8,
   parameter int CREDIT_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [CHAN_W-1:0] chan,
   input  logic              eop,
   input  logic              mod_nz,
   output viol_t             viol,
   output logic [CHAN_W-1:0] prev_chan
);
   localparam int WPC = words_per_credit(DATA_W, CREDIT_BYTES);
   localparam int CW  = (WPC > 1) ? $clog2(WPC) : 1;

   logic [CW-1:0]     cnt_q, cnt_base, cnt_inc;
   logic [CHAN_W-1:0] chan_q;
   logic              eop_q;
   logic              chan_chg;
   logic              at_bnd;

   assign chan_chg  = (chan != chan_q);
   assign prev_chan = chan_q;

   generate
      if ((1 << CW) == WPC) begin : g_pow2
         // natural wrap of the counter marks the boundary
         assign cnt_inc = cnt_base + 1'b1;
      end else begin : g_mod
         assign cnt_inc = (cnt_base == CW'(WPC - 1)) ? '0 : cnt_base + 1'b1;
      end
   endgenerate

   assign at_bnd   = (cnt_q == '0);
   assign cnt_base = chan_chg ? '0 : cnt_q;

   assign viol.addr = !eop_q && chan_chg && !at_bnd;
   assign viol.modv = mod_nz && !eop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         chan_q <= '0;
         eop_q  <= 1'b1;
      end else if (accept) begin
         cnt_q  <= eop ? '0 : cnt_inc;
         chan_q <= chan;
         eop_q  <= eop;
      end
   end

endmodule

// File: rtl/fwpc_repair.sv
module fwpc_repair
   import fwpc_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CHAN_W = 8,
   parameter int MOD_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] in_data,
   input  logic [CHAN_W-1:0] in_chan,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic [MOD_W-1:0]  in_mod,
   input  logic              in_err,
   input  viol_t             viol,
   input  logic [CHAN_W-1:0] old_chan,
   output logic              ready,
   output logic              o_valid,
   output logic [DATA_W-1:0] o_data,
   output logic [CHAN_W-1:0] o_chan,
   output logic              o_sop,
   output logic              o_eop,
   output logic              o_abort,
   output logic [MOD_W-1:0]  o_mod,
   output logic              o_err
);
   logic              pend_q;
   logic [DATA_W-1:0] p_data;
   logic [CHAN_W-1:0] p_chan;
   logic              p_sop, p_eop, p_err;
   logic [MOD_W-1:0]  p_mod;
   logic [MOD_W-1:0]  fix_mod;

   assign fix_mod = viol.modv ? '0 : in_mod;
   assign ready   = !pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         p_data  <= '0;
         p_chan  <= '0;
         p_sop   <= 1'b0;
         p_eop   <= 1'b0;
         p_mod   <= '0;
         p_err   <= 1'b0;
         o_valid <= 1'b0;
         o_data  <= '0;
         o_chan  <= '0;
         o_sop   <= 1'b0;
         o_eop   <= 1'b0;
         o_abort <= 1'b0;
         o_mod   <= '0;
         o_err   <= 1'b0;
      end else begin
         o_valid <= 1'b0;
         o_abort <= 1'b0;
         if (pend_q) begin
            pend_q  <= 1'b0;
            o_valid <= 1'b1;
            o_data  <= p_data;
            o_chan  <= p_chan;
            o_sop   <= p_sop;
            o_eop   <= p_eop;
            o_mod   <= p_mod;
            o_err   <= p_err;
         end else if (accept) begin
            o_valid <= 1'b1;
            if (viol.addr) begin
               // close the interrupted packet, park the new word
               o_data  <= '0;
               o_chan  <= old_chan;
               o_sop   <= 1'b0;
               o_eop   <= 1'b1;
               o_abort <= 1'b1;
               o_mod   <= '0;
               o_err   <= 1'b0;
               pend_q  <= 1'b1;
               p_data  <= in_data;
               p_chan  <= in_chan;
               p_sop   <= in_sop;
               p_eop   <= in_eop;
               p_mod   <= fix_mod;
               p_err   <= in_err;
            end else begin
               o_data  <= in_data;
               o_chan  <= in_chan;
               o_sop   <= in_sop;
               o_eop   <= in_eop;
               o_mod   <= fix_mod;
               o_err   <= in_err;
            end
         end
      end
   end

endmodule

// File: rtl/fwpc_status.sv
module fwpc_status (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic clr,
   output logic sticky,
   output logic pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky <= 1'b0;
         pulse  <= 1'b0;
      end else begin
         pulse <= hit;
         if (hit)      sticky <= 1'b1;
         else if (clr) sticky <= 1'b0;
      end
   end
endmodule

// File: rtl/fifo_wr_pattern_chk.sv
module fifo_wr_pattern_chk
   import fwpc_pkg::*;
#(
   parameter  int DATA_W       = 64,
   parameter  int CHAN_W       = 8,
   parameter  int CREDIT_BYTES = 16,
   localparam int MOD_W        = $clog2(DATA_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CHAN_W-1:0] wr_chan,
   input  logic              wr_sop,
   input  logic              wr_eop,
   input  logic [MOD_W-1:0]  wr_mod,
   input  logic              wr_err,
   output logic              ff_valid,
   output logic [DATA_W-1:0] ff_data,
   output logic [CHAN_W-1:0] ff_chan,
   output logic              ff_sop,
   output logic              ff_eop,
   output logic              ff_abort,
   output logic [MOD_W-1:0]  ff_mod,
   output logic              ff_err,
   input  logic              err_clr,
   output logic              pat_err,
   output logic              pat_err_pulse
);
   generate
      if (!(DATA_W == 32 || DATA_W == 64)) begin : g_bad_width
         $error("fifo_wr_pattern_chk: DATA_W must be 32 or 64");
      end
      if ((CREDIT_BYTES % (DATA_W / 8)) != 0 || (CREDIT_BYTES / (DATA_W / 8)) < 2) begin : g_bad_credit
         $error("fifo_wr_pattern_chk: credit must span at least two whole words");
      end
   endgenerate

   logic              accept;
   viol_t             viol;
   logic [CHAN_W-1:0] prev_chan;

   assign accept = wr_valid && wr_ready;

   fwpc_credit_track #(
      .DATA_W       (DATA_W),
      .CHAN_W       (CHAN_W),
      .CREDIT_BYTES (CREDIT_BYTES)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .chan      (wr_chan),
      .eop       (wr_eop),
      .mod_nz    (|wr_mod),
      .viol      (viol),
      .prev_chan (prev_chan)
   );

   fwpc_repair #(
      .DATA_W (DATA_W),
      .CHAN_W (CHAN_W),
      .MOD_W  (MOD_W)
   ) u_repair (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .in_data  (wr_data),
      .in_chan  (wr_chan),
      .in_sop   (wr_sop),
      .in_eop   (wr_eop),
      .in_mod   (wr_mod),
      .in_err   (wr_err),
      .viol     (viol),
      .old_chan (prev_chan),
      .ready    (wr_ready),
      .o_valid  (ff_valid),
      .o_data   (ff_data),
      .o_chan   (ff_chan),
      .o_sop    (ff_sop),
      .o_eop    (ff_eop),
      .o_abort  (ff_abort),
      .o_mod    (ff_mod),
      .o_err    (ff_err)
   );

   fwpc_status u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (accept && (viol.addr || viol.modv)),
      .clr    (err_clr),
      .sticky (pat_err),
      .pulse  (pat_err_pulse)
   );

endmodule

// File: rtl/fwpc_checker.sv
module fwpc_checker #(
   parameter int CHAN_W = 8,
   parameter int MOD_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic              ff_valid,
   input logic [CHAN_W-1:0] ff_chan,
   input logic              ff_sop,
   input logic              ff_eop,
   input logic              ff_abort,
   input logic [MOD_W-1:0]  ff_mod,
   input logic              err_clr,
   input logic              pat_err,
   input logic              pat_err_pulse
);
   assert_accept_forwards_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_ready |=> ff_valid);

   assert_marker_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ff_valid && ff_abort |-> ff_eop && !ff_sop && ff_mod == '0);

   assert_marker_then_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ff_valid && ff_abort |=> ff_valid && !ff_abort && ff_chan != $past(ff_chan));

   assert_stall_during_marker_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ff_valid && ff_abort |-> !wr_ready);

   assert_stall_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ff_valid && ff_abort |=> wr_ready);

   assert_mod_zero_mid_packet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ff_valid && !ff_eop |-> ff_mod == '0);

   assert_sticky_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pat_err && !err_clr |=> pat_err);

   assert_pulse_with_output_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pat_err_pulse |-> pat_err && ff_valid);
endmodule

bind fifo_wr_pattern_chk fwpc_checker #(
   .CHAN_W (CHAN_W),
   .MOD_W  (MOD_W)
) u_fwpc_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_valid      (wr_valid),
   .wr_ready      (wr_ready),
   .ff_valid      (ff_valid),
   .ff_chan       (ff_chan),
   .ff_sop        (ff_sop),
   .ff_eop        (ff_eop),
   .ff_abort      (ff_abort),
   .ff_mod        (ff_mod),
   .err_clr       (err_clr),
   .pat_err       (pat_err),
   .pat_err_pulse (pat_err_pulse)
);

// File: tb/fifo_wr_pattern_chk_bench.sv
module fifo_wr_pattern_chk_bench;
   localparam int DATA_W = 64;
   localparam int CHAN_W = 8;
   localparam int MOD_W  = 3;
   localparam int WPC    = 16 / (DATA_W / 8);

   logic              clk = 1'b0;
   logic              rst_n;
   logic              wr_valid, wr_ready, wr_sop, wr_eop, wr_err, err_clr;
   logic [DATA_W-1:0] wr_data;
   logic [CHAN_W-1:0] wr_chan;
   logic [MOD_W-1:0]  wr_mod;
   logic              ff_valid, ff_sop, ff_eop, ff_abort, ff_err, pat_err, pat_err_pulse;
   logic [DATA_W-1:0] ff_data;
   logic [CHAN_W-1:0] ff_chan;
   logic [MOD_W-1:0]  ff_mod;

   always #4 clk = ~clk;

   fifo_wr_pattern_chk #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .CREDIT_BYTES(16)) u_fifo_wr_pattern_chk (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_data(wr_data), .wr_chan(wr_chan), .wr_sop(wr_sop), .wr_eop(wr_eop),
      .wr_mod(wr_mod), .wr_err(wr_err), .ff_valid(ff_valid), .ff_data(ff_data),
      .ff_chan(ff_chan), .ff_sop(ff_sop), .ff_eop(ff_eop), .ff_abort(ff_abort),
      .ff_mod(ff_mod), .ff_err(ff_err), .err_clr(err_clr), .pat_err(pat_err),
      .pat_err_pulse(pat_err_pulse));

   typedef struct packed {
      logic [DATA_W-1:0] data;
      logic [CHAN_W-1:0] chan;
      logic              sop, eop, abort;
      logic [MOD_W-1:0]  modv;
      logic              err, pulse;
   } item_t;

   item_t             exp_q[$];
   int                checks = 0, errors = 0;
   bit                running = 1'b0, done = 1'b0;
   logic [CHAN_W-1:0] m_chan = '0;
   logic              m_eop = 1'b1;
   int                m_cnt = 0;
   logic              exp_perr = 1'b0;

   task automatic check(input bit ok, input string msg);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s", msg);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // Driver: applies one write and queues what the FIFO side must receive.
   task automatic send(input logic [CHAN_W-1:0] ch, input logic [DATA_W-1:0] d,
                       input logic sop, input logic eop, input logic [MOD_W-1:0] md,
                       input logic er, input logic clr);
      bit    av, mv;
      item_t it;
      @(negedge clk);
      while (!wr_ready) @(negedge clk);
      wr_valid = 1'b1; wr_chan = ch; wr_data = d; wr_sop = sop; wr_eop = eop;
      wr_mod = md; wr_err = er; err_clr = clr;
      av = !m_eop && (ch != m_chan) && ((m_cnt % WPC) != 0);
      mv = (md != '0) && !eop;
      if (av) begin
         it = '{data: '0, chan: m_chan, sop: 1'b0, eop: 1'b1, abort: 1'b1,
                modv: '0, err: 1'b0, pulse: 1'b1};
         exp_q.push_back(it);
      end
      it = '{data: d, chan: ch, sop: sop, eop: eop, abort: 1'b0,
             modv: mv ? '0 : md, err: er, pulse: !av && mv};
      exp_q.push_back(it);
      if (eop)              m_cnt = 0;
      else if (ch != m_chan) m_cnt = 1;
      else                  m_cnt = m_cnt + 1;
      m_chan = ch;
      m_eop  = eop;
      @(posedge clk);
      if (av || mv)   exp_perr = 1'b1;
      else if (clr)   exp_perr = 1'b0;
      #1;
      wr_valid = 1'b0; err_clr = 1'b0; wr_mod = '0;
   endtask

   task automatic clear_err();
      @(negedge clk);
      err_clr = 1'b1;
      @(posedge clk);
      exp_perr = 1'b0;
      #1 err_clr = 1'b0;
   endtask

   // Monitor: pops expected items as the design writes the FIFO side.
   always @(negedge clk) begin
      if (running && rst_n) begin
         if (ff_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, $sformatf("R2 unexpected output actual chan=%0h expected none", ff_chan));
            end else begin
               item_t e, a;
               string tag;
               e = exp_q.pop_front();
               a = '{data: ff_data, chan: ff_chan, sop: ff_sop, eop: ff_eop, abort: ff_abort,
                     modv: ff_mod, err: ff_err, pulse: pat_err_pulse};
               tag = e.abort ? "R5" : (e.pulse ? "R8/R11" : "R2");
               check(a == e, $sformatf("%s output word actual=%h expected=%h", tag, a, e));
            end
         end else begin
            check(!pat_err_pulse, "R11 pulse without output word actual=1 expected=0");
         end
         check(pat_err == exp_perr,
               $sformatf("R10 sticky error actual=%0b expected=%0b", pat_err, exp_perr));
      end
   end

   initial begin
      #(200000 * 8);
      check(1'b0, "watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b1; wr_valid = 1'b0; wr_data = '0; wr_chan = '0; wr_sop = 1'b0;
      wr_eop = 1'b0; wr_mod = '0; wr_err = 1'b0; err_clr = 1'b0;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(!ff_valid && !pat_err && !pat_err_pulse && wr_ready,
            $sformatf("R1 in reset actual v=%0b e=%0b p=%0b r=%0b expected 0 0 0 1",
                      ff_valid, pat_err, pat_err_pulse, wr_ready));
      rst_n = 1'b1;
      running = 1'b1;
      @(negedge clk);
      check(!ff_valid && !pat_err && !pat_err_pulse && wr_ready,
            $sformatf("R1 after reset actual v=%0b e=%0b p=%0b r=%0b expected 0 0 0 1",
                      ff_valid, pat_err, pat_err_pulse, wr_ready));

      // R2, R9: legal packet ending with a non-zero modulo on EOP
      send(8'h01, 64'h1111_0000_0000_0001, 1, 0, 0, 0, 0);
      send(8'h01, 64'h1111_0000_0000_0002, 0, 0, 0, 1, 0);
      send(8'h01, 64'h1111_0000_0000_0003, 0, 1, 3'd3, 0, 0);

      // R3: switch channel exactly on a credit boundary (2 words in)
      send(8'h02, 64'h2222_0000_0000_0001, 1, 0, 0, 0, 0);
      send(8'h02, 64'h2222_0000_0000_0002, 0, 0, 0, 0, 0);
      send(8'h03, 64'h3333_0000_0000_0001, 1, 0, 0, 0, 0);
      send(8'h03, 64'h3333_0000_0000_0002, 0, 1, 3'd7, 0, 0);

      // R7: switch right after an EOP at an odd word count
      send(8'h04, 64'h4444_0000_0000_0001, 1, 1, 3'd1, 0, 0);
      send(8'h05, 64'h5555_0000_0000_0001, 1, 0, 0, 0, 0);
      send(8'h05, 64'h5555_0000_0000_0002, 0, 1, 0, 0, 0);

      // R4, R5, R6: switch one word into a credit without EOP
      send(8'h06, 64'h6666_0000_0000_0001, 1, 0, 0, 0, 0);
      send(8'h07, 64'h7777_0000_0000_0001, 1, 0, 0, 1, 0);
      @(negedge clk);
      check(!wr_ready, $sformatf("R6 ready during marker actual=%0b expected=0", wr_ready));
      @(negedge clk);
      check(wr_ready, $sformatf("R6 ready after marker actual=%0b expected=1", wr_ready));

      clear_err();

      // R8: non-zero modulo mid-packet is zeroed, no abort
      send(8'h07, 64'h7777_0000_0000_0002, 0, 0, 3'd5, 0, 0);
      send(8'h07, 64'h7777_0000_0000_0003, 0, 1, 3'd2, 0, 0);
      clear_err();

      // R12: off-boundary switch with a bad modulo on the same word
      send(8'h08, 64'h8888_0000_0000_0001, 1, 0, 0, 0, 0);
      send(8'h09, 64'h9999_0000_0000_0001, 1, 0, 3'd2, 0, 0);

      // R10: clear coinciding with a new violation keeps the sticky bit
      send(8'h09, 64'h9999_0000_0000_0002, 0, 0, 3'd1, 0, 1);
      send(8'h09, 64'h9999_0000_0000_0003, 0, 1, 0, 0, 0);
      clear_err();

      // back-to-back legal traffic after clearing
      for (int i = 0; i < 6; i++)
         send(8'h0A, 64'hAAAA_0000_0000_0000 + 64'(i), i == 0, i == 5, i == 5 ? 3'd4 : 3'd0, i[0], 0);

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0,
            $sformatf("R2 words left undelivered actual=%0d expected=0", exp_q.size()));
      finish_run();
   end

endmodule